// File: doc/BRIEF.md
# Per-CPU Interrupt Priority Presenter

This block is the processor-side end of an interrupt controller for a single CPU. Sources (routed to this CPU elsewhere) send raise and clear pulses. Each source also drives its 4-bit priority, its vector and a flag that says whether it is level- or edge-sensitive. The presenter keeps two bit sets over the source IDs: a raised set of pending requests and an in-service set of requests the CPU has accepted. It also holds a 4-bit task priority. From these it drives one interrupt line to the CPU.

The CPU uses a small register window. It can set its task priority and read back its own index. Reading the acknowledge register takes the best pending request and returns its vector; if there is nothing to take, the read returns a spurious vector. Writing the end-of-interrupt register retires the most important request in service. A request is kept even when its priority is too low to be presented, so lowering the task priority later can bring it forward. Nesting works by comparison with the highest priority in service. On every acknowledge read, the block sends an acknowledge pulse tagged with the chosen source ID, so that edge sources can drop their pending state.

Top module: `cpu_irq_presenter`

## Requirements
- R1: After reset the task priority reads 15, both sets are empty, `irq_out` is 0, and an acknowledge read returns the spurious vector (all ones in `VEC_W` bits) with `ack_valid` low.
- R2: A raise pulse enters the raised set even when its priority is at or below the task priority. A later task-priority write to a lower value then presents it.
- R3: The best entry of a set is the one with the highest priority. On a tie, the lowest source ID wins.
- R4: `irq_out` in cycle n+1 is 1 exactly when, in cycle n, the raised set is non-empty, its best priority exceeds the task priority, and its best priority exceeds the best in-service priority (an empty in-service set counts as -1). The only exception is R11.
- R5: Register map, read when `reg_en`=1 and `reg_we`=0: 0x080 returns the task priority in bits 3:0; 0x090 returns `CPU_ID`; 0x0A0 is the acknowledge read; 0x0B0 returns 0; any other offset returns all ones. A write to 0x080 stores `reg_wdata[3:0]`. Writes to 0x090 and 0x0A0 change nothing.
- R6: An acknowledge read whose best raised priority exceeds the task priority returns that entry's vector, zero-extended. The entry joins the in-service set at the clock edge.
- R7: An acknowledge read returns the spurious vector, and leaves the in-service set unchanged, when the raised set is empty or its best priority does not exceed the task priority.
- R8: On any acknowledge read with a non-empty raised set, `ack_valid` is 1 and `ack_id` names the chosen entry in the same cycle. An edge entry (`src_level`=0) leaves the raised set; a level entry stays until `src_clr`.
- R9: A write to 0x0B0 removes the best in-service entry (R3 order). With an empty in-service set it does nothing.
- R10: A raised entry whose priority is not above the best in-service priority does not assert `irq_out`.
- R11: In the cycle after an acknowledge read, `irq_out` is 0, even if a higher request arrived in the same cycle. In the following cycle `irq_out` follows R4 again.
- R12: A raise pulse for a source takes precedence over a clear pulse, and over an acknowledge removal of that source, in the same cycle. The source stays raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_set | input | NSRC | Per-source raise pulse |
| src_clr | input | NSRC | Per-source clear pulse |
| src_level | input | NSRC | 1 = level-sensitive source, 0 = edge |
| src_prio | input | NSRC*4 | Per-source priority, source i in bits 4i+3:4i |
| src_vec | input | NSRC*VEC_W | Per-source vector, source i at VEC_W*i |
| reg_en | input | 1 | Register access this cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Register offset |
| reg_wdata | input | 4 | Write data (task priority field) |
| reg_rdata | output | 32 | Read data, valid in the access cycle |
| irq_out | output | 1 | Interrupt line to the CPU |
| ack_valid | output | 1 | Acknowledge pulse to the sources |
| ack_id | output | $clog2(NSRC) | Source taken by the acknowledge |

## Verification
The two functions that can fall in the same cycle are an acknowledge read and a source raise pulse, either for a higher-priority source or for the very source being taken. The bench provokes both by driving the raise pulse during the acknowledge read. It then judges `irq_out`, which must be forced low for one cycle and then rise for the newcomer. It also judges the raised set, read back through later acknowledge reads, which must still hold a source whose raise collided with its own acknowledge removal. A behavioural model built from queues and integers follows every cycle and is compared against `irq_out`, `reg_rdata`, `ack_valid` and `ack_id`.

// File: rtl/cip_pkg.sv
package cip_pkg;
  localparam int PRIO_W = 4;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;

  typedef logic [PRIO_W-1:0] prio_t;

  localparam logic [ADDR_W-1:0] OFS_TASKPRI = 12'h080;
  localparam logic [ADDR_W-1:0] OFS_WHOAMI  = 12'h090;
  localparam logic [ADDR_W-1:0] OFS_ACK     = 12'h0A0;
  localparam logic [ADDR_W-1:0] OFS_EOI     = 12'h0B0;

  // a outranks b when a exists and b is empty (-1) or strictly lower
  function automatic logic outranks(logic a_v, prio_t a_p, logic b_v, prio_t b_p);
    return a_v && (!b_v || (a_p > b_p));
  endfunction

  // an entry clears the task threshold only when strictly above it
  function automatic logic above_task(logic v, prio_t p, prio_t task_p);
    return v && (p > task_p);
  endfunction
endpackage

// File: rtl/cip_pick.sv
module cip_pick
  import cip_pkg::*;
#(
  parameter int NSRC = 8
) (
  input  logic [NSRC-1:0]        member,
  input  logic [NSRC*PRIO_W-1:0] prio_flat,
  output logic                   hit,
  output logic [$clog2(NSRC)-1:0] id,
  output prio_t                  prio
);
  localparam int IDX_W = $clog2(NSRC);

  // ascending scan, replace only on strictly greater: lowest ID wins ties
  always_comb begin
    hit  = 1'b0;
    id   = '0;
    prio = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (member[i] && (!hit || (prio_flat[i*PRIO_W +: PRIO_W] > prio))) begin
        hit  = 1'b1;
        id   = IDX_W'(i);
        prio = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/cip_set.sv
module cip_set #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] adds,
  input  logic [NSRC-1:0] drops,
  output logic [NSRC-1:0] members
);
  // an add in the same cycle as a drop keeps the bit
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= adds[i] | (bit_q & ~drops[i]);
    end
    assign members[i] = bit_q;
  end
endmodule

// File: rtl/cpu_irq_presenter.sv
module cpu_irq_presenter
  import cip_pkg::*;
#(
  parameter int NSRC   = 8,
  parameter int VEC_W  = 8,
  parameter int CPU_ID = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0]          src_set,
  input  logic [NSRC-1:0]          src_clr,
  input  logic [NSRC-1:0]          src_level,
  input  logic [NSRC*PRIO_W-1:0]   src_prio,
  input  logic [NSRC*VEC_W-1:0]    src_vec,
  input  logic                     reg_en,
  input  logic                     reg_we,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [PRIO_W-1:0]        reg_wdata,
  output logic [DATA_W-1:0]        reg_rdata,
  output logic                     irq_out,
  output logic                     ack_valid,
  output logic [$clog2(NSRC)-1:0]  ack_id
);
  localparam int IDX_W = $clog2(NSRC);
  localparam logic [VEC_W-1:0] SPUR = {VEC_W{1'b1}};

  // named internal events
  logic              rd_ack, wr_eoi, wr_task;
  logic              r_hit, s_hit;
  logic [IDX_W-1:0]  r_id, s_id;
  prio_t             r_prio, s_prio;
  logic              ack_take, edge_drop, eoi_pop, present;
  logic [NSRC-1:0]   raised_q, insvc_q;
  logic [NSRC-1:0]   r_drops, s_adds, s_drops;
  prio_t             task_q;
  logic              irq_q;

  assign rd_ack  = reg_en && !reg_we && (reg_addr == OFS_ACK);
  assign wr_eoi  = reg_en &&  reg_we && (reg_addr == OFS_EOI);
  assign wr_task = reg_en &&  reg_we && (reg_addr == OFS_TASKPRI);

  cip_pick #(.NSRC(NSRC)) u_pick_raised (
    .member(raised_q), .prio_flat(src_prio),
    .hit(r_hit), .id(r_id), .prio(r_prio));

  cip_pick #(.NSRC(NSRC)) u_pick_insvc (
    .member(insvc_q), .prio_flat(src_prio),
    .hit(s_hit), .id(s_id), .prio(s_prio));

  assign ack_take  = rd_ack && above_task(r_hit, r_prio, task_q);
  assign edge_drop = rd_ack && r_hit && !src_level[r_id];
  assign eoi_pop   = wr_eoi && s_hit;
  assign present   = above_task(r_hit, r_prio, task_q) &&
                     outranks(r_hit, r_prio, s_hit, s_prio);

  assign r_drops = src_clr | (edge_drop ? (NSRC'(1) << r_id) : '0);
  assign s_adds  = ack_take ? (NSRC'(1) << r_id) : '0;
  assign s_drops = eoi_pop  ? (NSRC'(1) << s_id) : '0;

  cip_set #(.NSRC(NSRC)) u_raised (
    .clk(clk), .rst_n(rst_n), .adds(src_set), .drops(r_drops), .members(raised_q));

  cip_set #(.NSRC(NSRC)) u_insvc (
    .clk(clk), .rst_n(rst_n), .adds(s_adds), .drops(s_drops), .members(insvc_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      task_q <= '1;
      irq_q  <= 1'b0;
    end else begin
      if (wr_task) task_q <= reg_wdata;
      irq_q <= rd_ack ? 1'b0 : present;
    end
  end

  always_comb begin
    reg_rdata = '1;
    if (reg_en && !reg_we) begin
      case (reg_addr)
        OFS_TASKPRI: reg_rdata = DATA_W'(task_q);
        OFS_WHOAMI:  reg_rdata = DATA_W'(CPU_ID);
        OFS_ACK:     reg_rdata = ack_take ? DATA_W'(src_vec[r_id*VEC_W +: VEC_W])
                                          : DATA_W'(SPUR);
        OFS_EOI:     reg_rdata = '0;
        default:     reg_rdata = '1;
      endcase
    end
  end

  assign irq_out   = irq_q;
  assign ack_valid = rd_ack && r_hit;
  assign ack_id    = r_id;
endmodule

// File: rtl/cip_presenter_chk.sv
module cip_presenter_chk
  import cip_pkg::*;
#(
  parameter int NSRC   = 8,
  parameter int VEC_W  = 8,
  parameter int CPU_ID = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    reg_en,
  input logic                    reg_we,
  input logic [ADDR_W-1:0]       reg_addr,
  input logic [DATA_W-1:0]       reg_rdata,
  input logic                    irq_out,
  input logic                    rd_ack,
  input logic                    ack_take,
  input logic                    eoi_pop,
  input logic                    r_hit,
  input logic [$clog2(NSRC)-1:0] r_id,
  input logic [NSRC-1:0]         insvc_q
);
  localparam logic [VEC_W-1:0] SPUR = {VEC_W{1'b1}};

  a_r11_ack_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |=> !irq_out);

  a_r6_ack_enters_service: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> insvc_q[$past(r_id)]);

  a_r9_eoi_pops_one: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_pop |=> ($countones(insvc_q) == $past($countones(insvc_q)) - 1));

  a_r7_spurious_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !r_hit) |-> (reg_rdata == DATA_W'(SPUR)));

  a_r5_whoami: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && !reg_we && reg_addr == OFS_WHOAMI) |-> (reg_rdata == DATA_W'(CPU_ID)));

  a_r4_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> $past(r_hit));
endmodule

bind cpu_irq_presenter cip_presenter_chk #(.NSRC(NSRC), .VEC_W(VEC_W), .CPU_ID(CPU_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .irq_out(irq_out), .rd_ack(rd_ack), .ack_take(ack_take),
  .eoi_pop(eoi_pop), .r_hit(r_hit), .r_id(r_id), .insvc_q(insvc_q));

// File: tb/tb_cpu_irq_presenter.sv
`timescale 1ns/100ps
module tb_cpu_irq_presenter;
  localparam int N  = 8;
  localparam int VW = 8;
  localparam int ID = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [N-1:0]    s_set = '0, s_clr = '0, s_lvl = 8'b0100_1000;
  logic [N*4-1:0]  s_prio;
  logic [N*VW-1:0] s_vec;
  logic            en = 1'b0, we = 1'b0;
  logic [11:0]     addr = '0;
  logic [3:0]      wd = '0;
  logic [31:0]     rdata;
  logic            irq, av;
  logic [2:0]      aid;

  int  pr[N] = '{2, 4, 5, 9, 1, 11, 9, 14};
  bit  m_r[N], m_s[N];
  int  m_task;
  bit  m_irq;
  int  checks = 0, fails = 0;
  string tag = "R1";
  bit  done = 1'b0;

  always_comb
    for (int i = 0; i < N; i++) begin
      s_prio[i*4 +: 4]   = pr[i][3:0];
      s_vec[i*VW +: VW]  = VW'(8'h40 + i);
    end

  cpu_irq_presenter #(.NSRC(N), .VEC_W(VW), .CPU_ID(ID)) dut (
    .clk(clk), .rst_n(rst_n), .src_set(s_set), .src_clr(s_clr), .src_level(s_lvl),
    .src_prio(s_prio), .src_vec(s_vec), .reg_en(en), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wd), .reg_rdata(rdata), .irq_out(irq), .ack_valid(av), .ack_id(aid));

  function automatic int best(input bit m[N]);
    int b = -1;
    for (int i = 0; i < N; i++)
      if (m[i] && (b < 0 || pr[i] > pr[b])) b = i;
    return b;
  endfunction

  task automatic check(string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got=%h exp=%h at %0t", tag, what, got, exp, $time);
    end
  endtask

  // one cycle: compare outputs, advance the model, move to next negedge
  task automatic tick();
    int rb, sb, sp;
    bit ack, take, cond;
    bit nr[N];
    #1;
    ack  = en && !we && addr == 12'h0A0;
    rb   = best(m_r);
    sb   = best(m_s);
    take = ack && rb >= 0 && pr[rb] > m_task;
    check("irq_out", 32'(irq), 32'(m_irq));
    if (en && !we) begin
      logic [31:0] e;
      case (addr)
        12'h080: e = 32'(m_task);
        12'h090: e = 32'(ID);
        12'h0A0: e = take ? 32'(8'h40 + rb) : 32'h0000_00FF;
        12'h0B0: e = 32'h0;
        default: e = 32'hFFFF_FFFF;
      endcase
      check("rdata", rdata, e);
    end
    check("ack_valid", 32'(av), 32'(ack && rb >= 0));
    if (ack && rb >= 0) check("ack_id", 32'(aid), 32'(rb));
    sp   = (sb >= 0) ? pr[sb] : -1;
    cond = rb >= 0 && pr[rb] > m_task && pr[rb] > sp;
    for (int i = 0; i < N; i++)
      nr[i] = s_set[i] || (m_r[i] && !s_clr[i] && !(ack && rb == i && !s_lvl[i]));
    m_r = nr;
    if (take) m_s[rb] = 1'b1;
    if (en && we && addr == 12'h0B0 && sb >= 0) m_s[sb] = 1'b0;
    if (en && we && addr == 12'h080) m_task = int'(wd);
    m_irq = ack ? 1'b0 : cond;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic rd(logic [11:0] a);
    en = 1; we = 0; addr = a; tick(); en = 0;
  endtask

  task automatic wr(logic [11:0] a, logic [3:0] d);
    en = 1; we = 1; addr = a; wd = d; tick(); en = 0; we = 0;
  endtask

  task automatic raise(logic [N-1:0] m);
    s_set = m; tick(); s_set = '0;
  endtask

  task automatic clear(logic [N-1:0] m);
    s_clr = m; tick(); s_clr = '0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired got=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_r[i] = 0; m_s[i] = 0; end
    m_task = 15; m_irq = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    tag = "R1";  rd(12'h080); rd(12'h0A0); idle(1);
    tag = "R5";  rd(12'h090); rd(12'h0B0); rd(12'h040); rd(12'h0A4);
    wr(12'h090, 4'h7); wr(12'h0A0, 4'h2); rd(12'h080);
    tag = "R2";  raise(8'h04); idle(3); wr(12'h080, 4'd3); idle(3);
    tag = "R5";  rd(12'h080);
    tag = "R6";  rd(12'h0A0); idle(1);
    tag = "R11"; idle(1);
    tag = "R10"; raise(8'h02); idle(3);
    tag = "R4";  raise(8'h20); idle(2);
    tag = "R6";  rd(12'h0A0); idle(2);
    tag = "R9";  wr(12'h0B0, 4'h0); idle(2); wr(12'h0B0, 4'h0); idle(3);
    tag = "R6";  rd(12'h0A0); wr(12'h0B0, 4'h0); idle(1);
    tag = "R9";  wr(12'h0B0, 4'h0); idle(1);
    tag = "R3";  raise(8'h48); idle(2); rd(12'h0A0); idle(1);
    tag = "R8";  rd(12'h0A0); clear(8'h08); rd(12'h0A0); clear(8'h40);
    wr(12'h0B0, 4'h0); wr(12'h0B0, 4'h0); wr(12'h0B0, 4'h0); idle(1);
    tag = "R7";  rd(12'h0A0); wr(12'h080, 4'd15); raise(8'h01); idle(1);
    rd(12'h0A0); wr(12'h080, 4'd0); idle(2); rd(12'h0A0);
    tag = "R12"; s_set = 8'h10; s_clr = 8'h10; tick(); s_set = '0; s_clr = '0; idle(2);
    en = 1; we = 0; addr = 12'h0A0; s_set = 8'h10; tick(); en = 0; s_set = '0; idle(2);
    wr(12'h0B0, 4'h0); idle(2); rd(12'h0A0); wr(12'h0B0, 4'h0); idle(1);
    tag = "R11"; raise(8'h04); idle(2);
    en = 1; we = 0; addr = 12'h0A0; s_set = 8'h80; tick(); en = 0; s_set = '0;
    idle(3); rd(12'h0A0); wr(12'h0B0, 4'h0); wr(12'h0B0, 4'h0); idle(2);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule